// File: doc/BRIEF.md
# Mixed-Width Dual-Port Memory with Parity Lanes

This block is a synchronous two-port memory holding 16,384 data bits and 2,048 parity bits. The two ports are fully independent: each has its own clock, enable, write enable, synchronous output set/reset, address, data and parity inputs, and registered data and parity outputs. A parameter gives each port a total width (data plus parity) chosen from 1, 2, 4, 9, 18 and 36. The two ports may pick different widths, so one side can write wide words while the other reads them back as narrow slices.

Each port's address width follows from its data width. Bit `b` of word `a` on a port with `d` data bits is the shared data bit `a*d + b`. Parity is mapped the same way into the parity store. Every control input, clock included, can be made active-low by a parameter. The output registers power up at, and can be forced to, a per-port constant.

Top module: `dpram_mixed`

## Requirements
- R1: A port width parameter outside {1, 2, 4, 9, 18, 36} stops elaboration. Widths 9, 18 and 36 carry 1, 2 and 4 parity bits, and the remaining widths carry none. On a port without parity, the parity ports are one bit wide, the parity input is ignored, and the parity output always reads 0.
- R2: The address width of a port is log2(16384 / d), where d is the total width minus the parity bits. Data bit b of word a sits at shared data bit a*d + b. Parity bit b of word a sits at shared parity bit a*p + b.
- R3: Storage changes only on an active clock edge where enable and write enable are both asserted and set/reset is deasserted.
- R4: On an active edge with enable asserted, write enable deasserted and set/reset deasserted, the outputs show the addressed word after that edge.
- R5: On a write edge, the outputs show the data and parity just written (write-first).
- R6: On an active edge with enable and set/reset asserted, the outputs load the port's constant (data and parity). No write happens, even when write enable is asserted.
- R7: On an active edge with enable deasserted, the outputs keep their value, whatever the other controls do.
- R8: Each of the clock, enable, write enable and set/reset inputs of each port has its own inversion parameter. An inverted clock acts on its falling edge, and an inverted control is active low.
- R9: The two ports run independently. Data written through one port is read back through the other at that port's own aspect ratio.
- R10: Before the first active edge, each port's outputs hold that port's set/reset constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| ssr_a | input | 1 | Port A synchronous output set/reset |
| addr_a | input | AW_A | Port A word address |
| din_a | input | DW_A | Port A write data |
| dinp_a | input | max(PW_A,1) | Port A write parity |
| dout_a | output | DW_A | Port A registered read data |
| doutp_a | output | max(PW_A,1) | Port A registered read parity |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| ssr_b | input | 1 | Port B synchronous output set/reset |
| addr_b | input | AW_B | Port B word address |
| din_b | input | DW_B | Port B write data |
| dinp_b | input | max(PW_B,1) | Port B write parity |
| dout_b | output | DW_B | Port B registered read data |
| doutp_b | output | max(PW_B,1) | Port B registered read parity |

## Verification
Two configurations are used. The first pairs a 36-bit port A with a 9-bit port B whose clock, enable and write enable are inverted. The second pairs a 1-bit port with a 4-bit port. Wide words written on one side and read back as bytes, single bits or nibbles on the other fix the lane order and the parity placement. A wrong lane shift or a swapped copy selection shows up as a misplaced byte or bit. Writes gated by a single missing control, set/reset combined with write enable, and disabled edges separate the write condition from the output-register behaviour. Driving the inverted port half a period away from its falling edge shows which clock edge it acts on.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

   localparam int unsigned TOTAL_DATA_BITS = 16384;
   localparam int unsigned ROW_DATA        = 32;
   localparam int unsigned ROW_PAR         = 4;
   localparam int unsigned ROWS            = TOTAL_DATA_BITS / ROW_DATA;
   localparam int unsigned ROW_AW          = $clog2(ROWS);

   typedef logic [ROW_DATA-1:0] row_data_t;
   typedef logic [ROW_PAR-1:0]  row_par_t;
   typedef logic [ROW_AW-1:0]   row_idx_t;

   // one port's write request, already aligned to a storage row
   typedef struct packed {
      logic      wr;
      row_idx_t  row;
      row_data_t dmask;
      row_data_t dval;
      row_par_t  pmask;
      row_par_t  pval;
   } wr_req_t;

   function automatic bit width_ok(input int unsigned w);
      return (w == 1) || (w == 2) || (w == 4) || (w == 9) || (w == 18) || (w == 36);
   endfunction

   function automatic int unsigned par_bits(input int unsigned w);
      case (w)
         9:       return 1;
         18:      return 2;
         36:      return 4;
         default: return 0;
      endcase
   endfunction

   function automatic int unsigned dat_bits(input int unsigned w);
      return (w > par_bits(w)) ? (w - par_bits(w)) : 1;
   endfunction

   function automatic int unsigned addr_bits(input int unsigned w);
      return $clog2(TOTAL_DATA_BITS / dat_bits(w));
   endfunction

   function automatic int unsigned par_port_bits(input int unsigned w);
      return (par_bits(w) == 0) ? 1 : par_bits(w);
   endfunction

endpackage

// File: rtl/dpram_ctl_pol.sv
module dpram_ctl_pol #(
   parameter bit INV_CLK = 1'b0,
   parameter bit INV_EN  = 1'b0,
   parameter bit INV_WE  = 1'b0,
   parameter bit INV_SSR = 1'b0
) (
   input  logic clk_raw,
   input  logic en_raw,
   input  logic we_raw,
   input  logic ssr_raw,
   output logic clk_eff,
   output logic en_eff,
   output logic we_eff,
   output logic ssr_eff,
   output logic do_write
);

   assign clk_eff  = clk_raw ^ INV_CLK;
   assign en_eff   = en_raw  ^ INV_EN;
   assign we_eff   = we_raw  ^ INV_WE;
   assign ssr_eff  = ssr_raw ^ INV_SSR;
   // set/reset has priority over the write
   assign do_write = en_eff & we_eff & ~ssr_eff;

endmodule

// File: rtl/dpram_port_map.sv
module dpram_port_map
   import dpram_pkg::*;
#(
   parameter  int unsigned WIDTH = 36,
   localparam int unsigned DW    = dat_bits(WIDTH),
   localparam int unsigned PW    = par_bits(WIDTH),
   localparam int unsigned PX    = par_port_bits(WIDTH),
   localparam int unsigned AW    = addr_bits(WIDTH),
   localparam int unsigned LSH   = AW - ROW_AW
) (
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   input  logic [PX-1:0] dinp,
   input  logic          do_write,
   output wr_req_t       req,
   output row_idx_t      row,
   input  row_data_t     rdat,
   input  row_par_t      rpar,
   output logic [DW-1:0] rd_dat,
   output logic [PX-1:0] rd_par
);

   localparam row_data_t      DMASK0 = row_data_t'((64'd1 << DW) - 64'd1);
   localparam row_par_t       PMASK0 = row_par_t'((8'd1 << PW) - 8'd1);
   localparam logic [PX-1:0]  PKEEP  = {PX{PW != 0}};

   logic [4:0]  lane;
   logic [31:0] dsh;
   logic [31:0] psh;

   generate
      if (LSH == 0) begin : g_full_row
         assign lane = '0;
         assign row  = addr;
      end else begin : g_sub_row
         assign lane = 5'(addr[LSH-1:0]);
         assign row  = addr[AW-1:LSH];
      end
   endgenerate

   assign dsh = lane * DW;
   assign psh = lane * PW;

   assign req.wr    = do_write;
   assign req.row   = row;
   assign req.dmask = DMASK0 << dsh;
   assign req.dval  = row_data_t'(din) << dsh;
   assign req.pmask = PMASK0 << psh;
   assign req.pval  = row_par_t'(dinp) << psh;

   assign rd_dat = DW'(rdat >> dsh);
   assign rd_par = PX'(rpar >> psh) & PKEEP;

endmodule

// File: rtl/dpram_out_reg.sv
module dpram_out_reg #(
   parameter int unsigned       DW    = 32,
   parameter int unsigned       PX    = 4,
   parameter logic [DW-1:0]     SR_D  = '0,
   parameter logic [PX-1:0]     SR_P  = '0,
   parameter logic [PX-1:0]     PKEEP = '1
) (
   input  logic          clk,
   input  logic          en,
   input  logic          we,
   input  logic          ssr,
   input  logic [DW-1:0] din,
   input  logic [PX-1:0] dinp,
   input  logic [DW-1:0] rd_dat,
   input  logic [PX-1:0] rd_par,
   output logic [DW-1:0] dout,
   output logic [PX-1:0] doutp
);

   logic [DW-1:0] q_d = SR_D;
   logic [PX-1:0] q_p = SR_P & PKEEP;

   always_ff @(posedge clk) begin
      if (en) begin
         if (ssr) begin
            q_d <= SR_D;
            q_p <= SR_P & PKEEP;
         end else if (we) begin
            q_d <= din;
            q_p <= dinp & PKEEP;
         end else begin
            q_d <= rd_dat;
            q_p <= rd_par & PKEEP;
         end
      end
   end

   assign dout  = q_d;
   assign doutp = q_p;

endmodule

// File: rtl/dpram_lvt_bank.sv
module dpram_lvt_bank
   import dpram_pkg::*;
(
   input  logic      clk_a,
   input  wr_req_t   req_a,
   input  row_idx_t  rrow_a,
   output row_data_t rdat_a,
   output row_par_t  rpar_a,
   input  logic      clk_b,
   input  wr_req_t   req_b,
   input  row_idx_t  rrow_b,
   output row_data_t rdat_b,
   output row_par_t  rpar_b
);

   // each port owns one copy and one tag array; a bit belongs to
   // port B's copy when the two tags differ, to port A's otherwise
   row_data_t cpy_a [ROWS];
   row_data_t cpy_b [ROWS];
   row_data_t tag_a [ROWS];
   row_data_t tag_b [ROWS];
   row_par_t  pcpy_a [ROWS];
   row_par_t  pcpy_b [ROWS];
   row_par_t  ptag_a [ROWS];
   row_par_t  ptag_b [ROWS];

   always_ff @(posedge clk_a) begin
      if (req_a.wr) begin
         cpy_a[req_a.row]  <= (cpy_a[req_a.row]  & ~req_a.dmask) | (req_a.dval & req_a.dmask);
         tag_a[req_a.row]  <= (tag_a[req_a.row]  & ~req_a.dmask) | (tag_b[req_a.row] & req_a.dmask);
         pcpy_a[req_a.row] <= (pcpy_a[req_a.row] & ~req_a.pmask) | (req_a.pval & req_a.pmask);
         ptag_a[req_a.row] <= (ptag_a[req_a.row] & ~req_a.pmask) | (ptag_b[req_a.row] & req_a.pmask);
      end
   end

   always_ff @(posedge clk_b) begin
      if (req_b.wr) begin
         cpy_b[req_b.row]  <= (cpy_b[req_b.row]  & ~req_b.dmask) | (req_b.dval & req_b.dmask);
         tag_b[req_b.row]  <= (tag_b[req_b.row]  & ~req_b.dmask) | (~tag_a[req_b.row] & req_b.dmask);
         pcpy_b[req_b.row] <= (pcpy_b[req_b.row] & ~req_b.pmask) | (req_b.pval & req_b.pmask);
         ptag_b[req_b.row] <= (ptag_b[req_b.row] & ~req_b.pmask) | (~ptag_a[req_b.row] & req_b.pmask);
      end
   end

   row_data_t sel_a, sel_b;
   row_par_t  psel_a, psel_b;

   assign sel_a  = tag_a[rrow_a] ^ tag_b[rrow_a];
   assign sel_b  = tag_a[rrow_b] ^ tag_b[rrow_b];
   assign psel_a = ptag_a[rrow_a] ^ ptag_b[rrow_a];
   assign psel_b = ptag_a[rrow_b] ^ ptag_b[rrow_b];

   assign rdat_a = (cpy_a[rrow_a] & ~sel_a) | (cpy_b[rrow_a] & sel_a);
   assign rdat_b = (cpy_a[rrow_b] & ~sel_b) | (cpy_b[rrow_b] & sel_b);
   assign rpar_a = (pcpy_a[rrow_a] & ~psel_a) | (pcpy_b[rrow_a] & psel_a);
   assign rpar_b = (pcpy_a[rrow_b] & ~psel_b) | (pcpy_b[rrow_b] & psel_b);

endmodule

// File: rtl/dpram_mixed.sv
module dpram_mixed
   import dpram_pkg::*;
#(
   parameter  int unsigned WIDTH_A      = 36,
   parameter  int unsigned WIDTH_B      = 9,
   parameter  bit          INV_CLK_A    = 1'b0,
   parameter  bit          INV_EN_A     = 1'b0,
   parameter  bit          INV_WE_A     = 1'b0,
   parameter  bit          INV_SSR_A    = 1'b0,
   parameter  bit          INV_CLK_B    = 1'b0,
   parameter  bit          INV_EN_B     = 1'b0,
   parameter  bit          INV_WE_B     = 1'b0,
   parameter  bit          INV_SSR_B    = 1'b0,
   parameter  logic [31:0] SRVAL_DATA_A = '0,
   parameter  logic [3:0]  SRVAL_PAR_A  = '0,
   parameter  logic [31:0] SRVAL_DATA_B = '0,
   parameter  logic [3:0]  SRVAL_PAR_B  = '0,
   localparam int unsigned DW_A         = dat_bits(WIDTH_A),
   localparam int unsigned PW_A         = par_bits(WIDTH_A),
   localparam int unsigned PX_A         = par_port_bits(WIDTH_A),
   localparam int unsigned AW_A         = addr_bits(WIDTH_A),
   localparam int unsigned DW_B         = dat_bits(WIDTH_B),
   localparam int unsigned PW_B         = par_bits(WIDTH_B),
   localparam int unsigned PX_B         = par_port_bits(WIDTH_B),
   localparam int unsigned AW_B         = addr_bits(WIDTH_B)
) (
   input  logic            clk_a,
   input  logic            en_a,
   input  logic            we_a,
   input  logic            ssr_a,
   input  logic [AW_A-1:0] addr_a,
   input  logic [DW_A-1:0] din_a,
   input  logic [PX_A-1:0] dinp_a,
   output logic [DW_A-1:0] dout_a,
   output logic [PX_A-1:0] doutp_a,
   input  logic            clk_b,
   input  logic            en_b,
   input  logic            we_b,
   input  logic            ssr_b,
   input  logic [AW_B-1:0] addr_b,
   input  logic [DW_B-1:0] din_b,
   input  logic [PX_B-1:0] dinp_b,
   output logic [DW_B-1:0] dout_b,
   output logic [PX_B-1:0] doutp_b
);

   localparam logic [PX_A-1:0] PKEEP_A = {PX_A{PW_A != 0}};
   localparam logic [PX_B-1:0] PKEEP_B = {PX_B{PW_B != 0}};

   // R1: only the six legal total widths elaborate
   generate
      if (!width_ok(WIDTH_A)) begin : g_bad_width_a
         $error("dpram_mixed: WIDTH_A must be 1, 2, 4, 9, 18 or 36");
      end
      if (!width_ok(WIDTH_B)) begin : g_bad_width_b
         $error("dpram_mixed: WIDTH_B must be 1, 2, 4, 9, 18 or 36");
      end
   endgenerate

   logic ck_a, ena, wea, ssra, wr_a;
   logic ck_b, enb, web, ssrb, wr_b;

   dpram_ctl_pol #(
      .INV_CLK (INV_CLK_A),
      .INV_EN  (INV_EN_A),
      .INV_WE  (INV_WE_A),
      .INV_SSR (INV_SSR_A)
   ) u_pol_a (
      .clk_raw  (clk_a),
      .en_raw   (en_a),
      .we_raw   (we_a),
      .ssr_raw  (ssr_a),
      .clk_eff  (ck_a),
      .en_eff   (ena),
      .we_eff   (wea),
      .ssr_eff  (ssra),
      .do_write (wr_a)
   );

   dpram_ctl_pol #(
      .INV_CLK (INV_CLK_B),
      .INV_EN  (INV_EN_B),
      .INV_WE  (INV_WE_B),
      .INV_SSR (INV_SSR_B)
   ) u_pol_b (
      .clk_raw  (clk_b),
      .en_raw   (en_b),
      .we_raw   (we_b),
      .ssr_raw  (ssr_b),
      .clk_eff  (ck_b),
      .en_eff   (enb),
      .we_eff   (web),
      .ssr_eff  (ssrb),
      .do_write (wr_b)
   );

   wr_req_t       req_a, req_b;
   row_idx_t      row_a, row_b;
   row_data_t     rdat_a, rdat_b;
   row_par_t      rpar_a, rpar_b;
   logic [DW_A-1:0] sl_dat_a;
   logic [PX_A-1:0] sl_par_a;
   logic [DW_B-1:0] sl_dat_b;
   logic [PX_B-1:0] sl_par_b;

   dpram_port_map #(.WIDTH(WIDTH_A)) u_map_a (
      .addr     (addr_a),
      .din      (din_a),
      .dinp     (dinp_a),
      .do_write (wr_a),
      .req      (req_a),
      .row      (row_a),
      .rdat     (rdat_a),
      .rpar     (rpar_a),
      .rd_dat   (sl_dat_a),
      .rd_par   (sl_par_a)
   );

   dpram_port_map #(.WIDTH(WIDTH_B)) u_map_b (
      .addr     (addr_b),
      .din      (din_b),
      .dinp     (dinp_b),
      .do_write (wr_b),
      .req      (req_b),
      .row      (row_b),
      .rdat     (rdat_b),
      .rpar     (rpar_b),
      .rd_dat   (sl_dat_b),
      .rd_par   (sl_par_b)
   );

   dpram_lvt_bank u_bank (
      .clk_a  (ck_a),
      .req_a  (req_a),
      .rrow_a (row_a),
      .rdat_a (rdat_a),
      .rpar_a (rpar_a),
      .clk_b  (ck_b),
      .req_b  (req_b),
      .rrow_b (row_b),
      .rdat_b (rdat_b),
      .rpar_b (rpar_b)
   );

   dpram_out_reg #(
      .DW    (DW_A),
      .PX    (PX_A),
      .SR_D  (SRVAL_DATA_A[DW_A-1:0]),
      .SR_P  (SRVAL_PAR_A[PX_A-1:0]),
      .PKEEP (PKEEP_A)
   ) u_oreg_a (
      .clk    (ck_a),
      .en     (ena),
      .we     (wea),
      .ssr    (ssra),
      .din    (din_a),
      .dinp   (dinp_a),
      .rd_dat (sl_dat_a),
      .rd_par (sl_par_a),
      .dout   (dout_a),
      .doutp  (doutp_a)
   );

   dpram_out_reg #(
      .DW    (DW_B),
      .PX    (PX_B),
      .SR_D  (SRVAL_DATA_B[DW_B-1:0]),
      .SR_P  (SRVAL_PAR_B[PX_B-1:0]),
      .PKEEP (PKEEP_B)
   ) u_oreg_b (
      .clk    (ck_b),
      .en     (enb),
      .we     (web),
      .ssr    (ssrb),
      .din    (din_b),
      .dinp   (dinp_b),
      .rd_dat (sl_dat_b),
      .rd_par (sl_par_b),
      .dout   (dout_b),
      .doutp  (doutp_b)
   );

endmodule

// File: rtl/dpram_mixed_chk.sv
module dpram_mixed_chk
   import dpram_pkg::*;
#(
   parameter  int unsigned WIDTH_A      = 36,
   parameter  int unsigned WIDTH_B      = 9,
   parameter  bit          INV_CLK_A    = 1'b0,
   parameter  bit          INV_EN_A     = 1'b0,
   parameter  bit          INV_WE_A     = 1'b0,
   parameter  bit          INV_SSR_A    = 1'b0,
   parameter  bit          INV_CLK_B    = 1'b0,
   parameter  bit          INV_EN_B     = 1'b0,
   parameter  bit          INV_WE_B     = 1'b0,
   parameter  bit          INV_SSR_B    = 1'b0,
   parameter  logic [31:0] SRVAL_DATA_A = '0,
   parameter  logic [3:0]  SRVAL_PAR_A  = '0,
   parameter  logic [31:0] SRVAL_DATA_B = '0,
   parameter  logic [3:0]  SRVAL_PAR_B  = '0,
   localparam int unsigned DW_A         = dat_bits(WIDTH_A),
   localparam int unsigned PW_A         = par_bits(WIDTH_A),
   localparam int unsigned PX_A         = par_port_bits(WIDTH_A),
   localparam int unsigned DW_B         = dat_bits(WIDTH_B),
   localparam int unsigned PW_B         = par_bits(WIDTH_B),
   localparam int unsigned PX_B         = par_port_bits(WIDTH_B)
) (
   input logic            clk_a,
   input logic            en_a,
   input logic            we_a,
   input logic            ssr_a,
   input logic [DW_A-1:0] din_a,
   input logic [PX_A-1:0] dinp_a,
   input logic [DW_A-1:0] dout_a,
   input logic [PX_A-1:0] doutp_a,
   input logic            clk_b,
   input logic            en_b,
   input logic            we_b,
   input logic            ssr_b,
   input logic [DW_B-1:0] din_b,
   input logic [PX_B-1:0] dinp_b,
   input logic [DW_B-1:0] dout_b,
   input logic [PX_B-1:0] doutp_b
);

   localparam logic [PX_A-1:0] PK_A  = {PX_A{PW_A != 0}};
   localparam logic [PX_B-1:0] PK_B  = {PX_B{PW_B != 0}};
   localparam logic [DW_A-1:0] SRD_A = SRVAL_DATA_A[DW_A-1:0];
   localparam logic [PX_A-1:0] SRP_A = SRVAL_PAR_A[PX_A-1:0] & PK_A;
   localparam logic [DW_B-1:0] SRD_B = SRVAL_DATA_B[DW_B-1:0];
   localparam logic [PX_B-1:0] SRP_B = SRVAL_PAR_B[PX_B-1:0] & PK_B;

   logic ck_a, ena, wea, ssra;
   logic ck_b, enb, web, ssrb;
   assign ck_a = clk_a ^ INV_CLK_A;
   assign ena  = en_a  ^ INV_EN_A;
   assign wea  = we_a  ^ INV_WE_A;
   assign ssra = ssr_a ^ INV_SSR_A;
   assign ck_b = clk_b ^ INV_CLK_B;
   assign enb  = en_b  ^ INV_EN_B;
   assign web  = we_b  ^ INV_WE_B;
   assign ssrb = ssr_b ^ INV_SSR_B;

   // no reset pin: properties start after the first active edge
   logic armed_a = 1'b0;
   logic armed_b = 1'b0;
   always_ff @(posedge ck_a) armed_a <= 1'b1;
   always_ff @(posedge ck_b) armed_b <= 1'b1;

   assert_ssr_load_R6_a: assert property (@(posedge ck_a) disable iff (!armed_a)
      (ena && ssra) |=> (dout_a == SRD_A && doutp_a == SRP_A))
      else $error("port A set/reset value not loaded");

   assert_ssr_load_R6_b: assert property (@(posedge ck_b) disable iff (!armed_b)
      (enb && ssrb) |=> (dout_b == SRD_B && doutp_b == SRP_B))
      else $error("port B set/reset value not loaded");

   assert_write_first_R5_a: assert property (@(posedge ck_a) disable iff (!armed_a)
      (ena && wea && !ssra) |=> (dout_a == $past(din_a) && doutp_a == ($past(dinp_a) & PK_A)))
      else $error("port A write-first output wrong");

   assert_write_first_R5_b: assert property (@(posedge ck_b) disable iff (!armed_b)
      (enb && web && !ssrb) |=> (dout_b == $past(din_b) && doutp_b == ($past(dinp_b) & PK_B)))
      else $error("port B write-first output wrong");

   assert_disabled_hold_R7_a: assert property (@(posedge ck_a) disable iff (!armed_a)
      !ena |=> ($stable(dout_a) && $stable(doutp_a)))
      else $error("port A output moved while disabled");

   assert_disabled_hold_R7_b: assert property (@(posedge ck_b) disable iff (!armed_b)
      !enb |=> ($stable(dout_b) && $stable(doutp_b)))
      else $error("port B output moved while disabled");

endmodule

bind dpram_mixed dpram_mixed_chk #(
   .WIDTH_A      (WIDTH_A),
   .WIDTH_B      (WIDTH_B),
   .INV_CLK_A    (INV_CLK_A),
   .INV_EN_A     (INV_EN_A),
   .INV_WE_A     (INV_WE_A),
   .INV_SSR_A    (INV_SSR_A),
   .INV_CLK_B    (INV_CLK_B),
   .INV_EN_B     (INV_EN_B),
   .INV_WE_B     (INV_WE_B),
   .INV_SSR_B    (INV_SSR_B),
   .SRVAL_DATA_A (SRVAL_DATA_A),
   .SRVAL_PAR_A  (SRVAL_PAR_A),
   .SRVAL_DATA_B (SRVAL_DATA_B),
   .SRVAL_PAR_B  (SRVAL_PAR_B)
) u_chk (
   .clk_a   (clk_a),
   .en_a    (en_a),
   .we_a    (we_a),
   .ssr_a   (ssr_a),
   .din_a   (din_a),
   .dinp_a  (dinp_a),
   .dout_a  (dout_a),
   .doutp_a (doutp_a),
   .clk_b   (clk_b),
   .en_b    (en_b),
   .we_b    (we_b),
   .ssr_b   (ssr_b),
   .din_b   (din_b),
   .dinp_b  (dinp_b),
   .dout_b  (dout_b),
   .doutp_b (doutp_b)
);

// File: tb/dpram_mixed_bench.sv
module dpram_mixed_bench;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   int checks   = 0;
   int failures = 0;

   // main instance: A 36 bits (32+4), B 9 bits (8+1) with inverted clock, enable, write enable
   logic        en_a = 0, we_a = 0, ssr_a = 0;
   logic [8:0]  addr_a = '0;
   logic [31:0] din_a = '0;
   logic [3:0]  dinp_a = '0;
   logic [31:0] dout_a;
   logic [3:0]  doutp_a;
   logic        en_b_n = 1, we_b_n = 1, ssr_b = 0;
   logic [10:0] addr_b = '0;
   logic [7:0]  din_b = '0;
   logic [0:0]  dinp_b = '0;
   logic [7:0]  dout_b;
   logic [0:0]  doutp_b;

   dpram_mixed #(
      .WIDTH_A(36), .WIDTH_B(9),
      .INV_CLK_B(1'b1), .INV_EN_B(1'b1), .INV_WE_B(1'b1),
      .SRVAL_DATA_A(32'hDEAD_BEEF), .SRVAL_PAR_A(4'hA),
      .SRVAL_DATA_B(32'h0000_005C), .SRVAL_PAR_B(4'h1)
   ) u_dpram_mixed (
      .clk_a(clk), .en_a(en_a), .we_a(we_a), .ssr_a(ssr_a), .addr_a(addr_a),
      .din_a(din_a), .dinp_a(dinp_a), .dout_a(dout_a), .doutp_a(doutp_a),
      .clk_b(clk), .en_b(en_b_n), .we_b(we_b_n), .ssr_b(ssr_b), .addr_b(addr_b),
      .din_b(din_b), .dinp_b(dinp_b), .dout_b(dout_b), .doutp_b(doutp_b)
   );

   // narrow instance: A 1 bit, B 4 bits, no parity
   logic        n_en_a = 0, n_we_a = 0, n_ssr_a = 0;
   logic [13:0] n_addr_a = '0;
   logic [0:0]  n_din_a = '0, n_dinp_a = '0, n_dout_a, n_doutp_a;
   logic        n_en_b = 0, n_we_b = 0, n_ssr_b = 0;
   logic [11:0] n_addr_b = '0;
   logic [3:0]  n_din_b = '0, n_dout_b;
   logic [0:0]  n_dinp_b = '0, n_doutp_b;

   dpram_mixed #(
      .WIDTH_A(1), .WIDTH_B(4),
      .SRVAL_PAR_A(4'hF), .SRVAL_DATA_B(32'h0000_0009), .SRVAL_PAR_B(4'hF)
   ) u_dpram_mixed_nrw (
      .clk_a(clk), .en_a(n_en_a), .we_a(n_we_a), .ssr_a(n_ssr_a), .addr_a(n_addr_a),
      .din_a(n_din_a), .dinp_a(n_dinp_a), .dout_a(n_dout_a), .doutp_a(n_doutp_a),
      .clk_b(clk), .en_b(n_en_b), .we_b(n_we_b), .ssr_b(n_ssr_b), .addr_b(n_addr_b),
      .din_b(n_din_b), .dinp_b(n_dinp_b), .dout_b(n_dout_b), .doutp_b(n_doutp_b)
   );

   // reference stores, indexed by shared bit address
   logic [16383:0] ref_d;
   logic [2047:0]  ref_p;
   logic [16383:0] ref_n;

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // port A acts on rising edge: drive at falling edge, sample just after rising
   task automatic a_do(input logic e, input logic w, input logic s,
                       input logic [8:0] ad, input logic [31:0] d, input logic [3:0] p);
      @(negedge clk);
      en_a = e; we_a = w; ssr_a = s; addr_a = ad; din_a = d; dinp_a = p;
      @(posedge clk); #1;
      if (e && w && !s) begin
         ref_d[ad*32 +: 32] = d;
         ref_p[ad*4 +: 4]   = p;
      end
      en_a = 0; we_a = 0; ssr_a = 0;
   endtask

   // port B acts on falling edge with active-low enable/write enable
   task automatic b_do(input logic e, input logic w, input logic s,
                       input logic [10:0] ad, input logic [7:0] d, input logic p);
      @(posedge clk);
      en_b_n = ~e; we_b_n = ~w; ssr_b = s; addr_b = ad; din_b = d; dinp_b = p;
      @(negedge clk); #1;
      if (e && w && !s) begin
         ref_d[ad*8 +: 8] = d;
         ref_p[ad]        = p;
      end
      en_b_n = 1; we_b_n = 1; ssr_b = 0;
   endtask

   task automatic na_do(input logic w, input logic [13:0] ad, input logic d);
      @(negedge clk);
      n_en_a = 1; n_we_a = w; n_addr_a = ad; n_din_a = d; n_dinp_a = 1'b1;
      @(posedge clk); #1;
      if (w) ref_n[ad] = d;
      n_en_a = 0; n_we_a = 0;
   endtask

   task automatic nb_do(input logic w, input logic [11:0] ad, input logic [3:0] d);
      @(negedge clk);
      n_en_b = 1; n_we_b = w; n_addr_b = ad; n_din_b = d; n_dinp_b = 1'b1;
      @(posedge clk); #1;
      if (w) ref_n[ad*4 +: 4] = d;
      n_en_b = 0; n_we_b = 0;
   endtask

   task automatic t_power_up;
      #1;
      chk("R10", "A data at power-up", 64'(dout_a), 64'h0000_0000_DEAD_BEEF);
      chk("R10", "A parity at power-up", 64'(doutp_a), 64'hA);
      chk("R10", "B data at power-up", 64'(dout_b), 64'h5C);
      chk("R10", "B parity at power-up", 64'(doutp_b), 64'h1);
      chk("R10", "narrow B data at power-up", 64'(n_dout_b), 64'h9);
      chk("R1", "narrow A parity masked at power-up", 64'(n_doutp_a), 64'h0);
   endtask

   task automatic t_write_first;
      a_do(1, 1, 0, 9'd3, 32'hCAFE_0123, 4'h5);
      chk("R5", "A write-first data", 64'(dout_a), 64'hCAFE_0123);
      chk("R5", "A write-first parity", 64'(doutp_a), 64'h5);
      b_do(1, 1, 0, 11'd100, 8'hA7, 1'b1);
      chk("R5", "B write-first data", 64'(dout_b), 64'hA7);
      chk("R5", "B write-first parity", 64'(doutp_b), 64'h1);
   endtask

   task automatic t_read_back;
      a_do(1, 1, 0, 9'd20, 32'h0BAD_F00D, 4'h6);
      a_do(1, 1, 0, 9'd21, 32'h1357_9BDF, 4'h9);
      a_do(1, 0, 0, 9'd20, 32'h0, 4'h0);
      chk("R4", "A read row 20", 64'(dout_a), 64'h0BAD_F00D);
      chk("R4", "A read parity row 20", 64'(doutp_a), 64'h6);
      a_do(1, 0, 0, 9'd21, 32'h0, 4'h0);
      chk("R4", "A read row 21", 64'(dout_a), 64'h1357_9BDF);
      b_do(1, 0, 0, 11'd12, 8'h0, 1'b0);
      chk("R9", "B reads byte 0 of A row 3", 64'(dout_b), 64'h23);
      chk("R2", "B reads parity bit 0 of A row 3", 64'(doutp_b), 64'h1);
   endtask

   task automatic t_cross_aspect;
      a_do(1, 1, 0, 9'd7, 32'h4433_2211, 4'b1010);
      for (int i = 28; i < 32; i++) begin
         b_do(1, 0, 0, 11'(i), 8'h0, 1'b0);
         chk("R2", $sformatf("B byte lane at %0d", i), 64'(dout_b), 64'(ref_d[i*8 +: 8]));
         chk("R2", $sformatf("B parity lane at %0d", i), 64'(doutp_b), 64'(ref_p[i]));
      end
      a_do(1, 1, 0, 9'd10, 32'h0, 4'hF);
      b_do(1, 1, 0, 11'd41, 8'h9E, 1'b0);
      a_do(1, 0, 0, 9'd10, 32'h0, 4'h0);
      chk("R9", "A sees B byte in lane 1", 64'(dout_a), 64'h0000_9E00);
      chk("R9", "A sees B parity in lane 1", 64'(doutp_a), 64'b1101);
   endtask

   task automatic t_gate_write;
      a_do(1, 0, 0, 9'd20, 32'h5555_5555, 4'h1);
      chk("R3", "A we low reads old word", 64'(dout_a), 64'h0BAD_F00D);
      a_do(0, 1, 0, 9'd20, 32'h7777_7777, 4'h2);
      a_do(1, 0, 0, 9'd20, 32'h0, 4'h0);
      chk("R3", "A en low leaves row 20", 64'(dout_a), 64'h0BAD_F00D);
      b_do(1, 0, 0, 11'd100, 8'h11, 1'b0);
      chk("R3", "B we inactive reads old byte", 64'(dout_b), 64'hA7);
      b_do(0, 1, 0, 11'd100, 8'h22, 1'b0);
      b_do(1, 0, 0, 11'd100, 8'h0, 1'b0);
      chk("R3", "B en inactive leaves byte", 64'(dout_b), 64'hA7);
   endtask

   task automatic t_ssr;
      a_do(1, 1, 1, 9'd21, 32'h1111_1111, 4'h3);
      chk("R6", "A set/reset data", 64'(dout_a), 64'hDEAD_BEEF);
      chk("R6", "A set/reset parity", 64'(doutp_a), 64'hA);
      a_do(1, 0, 0, 9'd21, 32'h0, 4'h0);
      chk("R6", "A set/reset blocked write", 64'(dout_a), 64'h1357_9BDF);
      b_do(1, 1, 1, 11'd100, 8'h33, 1'b0);
      chk("R6", "B set/reset data", 64'(dout_b), 64'h5C);
      chk("R6", "B set/reset parity", 64'(doutp_b), 64'h1);
   endtask

   task automatic t_hold;
      a_do(1, 0, 0, 9'd7, 32'h0, 4'h0);
      a_do(0, 0, 0, 9'd20, 32'h0, 4'h0);
      chk("R7", "A holds with en low", 64'(dout_a), 64'h4433_2211);
      a_do(0, 1, 1, 9'd20, 32'hFFFF_FFFF, 4'hF);
      chk("R7", "A holds with en low and ssr", 64'(dout_a), 64'h4433_2211);
      chk("R7", "A parity holds", 64'(doutp_a), 64'b1010);
   endtask

   task automatic t_clock_edge;
      // B was last left at byte 100 reset value 5C; read byte 28 = 8'h11
      @(negedge clk); #1;
      addr_b = 11'd28; en_b_n = 0; we_b_n = 1;
      @(posedge clk); #1;
      chk("R8", "B ignores rising edge", 64'(dout_b), 64'h5C);
      @(negedge clk); #1;
      chk("R8", "B acts on falling edge", 64'(dout_b), 64'h11);
      en_b_n = 1;
   endtask

   task automatic t_narrow;
      logic [7:0] pat = 8'b0100_1101;
      for (int i = 0; i < 8; i++) na_do(1, 14'(i), pat[i]);
      nb_do(0, 12'd0, 4'h0);
      chk("R2", "nibble 0 from single bits", 64'(n_dout_b), 64'hD);
      nb_do(0, 12'd1, 4'h0);
      chk("R2", "nibble 1 from single bits", 64'(n_dout_b), 64'h4);
      chk("R1", "narrow B parity reads 0", 64'(n_doutp_b), 64'h0);
      nb_do(1, 12'd5, 4'b0110);
      for (int i = 20; i < 24; i++) begin
         na_do(0, 14'(i), 1'b0);
         chk("R2", $sformatf("single bit %0d of nibble 5", i), 64'(n_dout_a), 64'(ref_n[i]));
      end
      chk("R1", "narrow A parity reads 0", 64'(n_doutp_a), 64'h0);
   endtask

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_power_up();
      t_write_first();
      t_read_back();
      t_cross_aspect();
      t_gate_write();
      t_ssr();
      t_hold();
      t_clock_edge();
      t_narrow();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule